// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This block carries out bit-level operations on one byte. An operation acts on one selected bit of an operand. The operand is either a general register value supplied with the request, or a memory byte that the block fetches itself. The operations are:

- forcing the bit to one or to zero, or flipping it;
- testing it into the zero flag;
- loading it into the carry flag, or storing the carry flag into it;
- combining it with the carry flag by AND, OR or XOR.

Load, store and the three combining operations each also have a variant that works on the complemented bit or carry. The bit number comes from a 3-bit immediate field. For set, clear, invert and test, the caller may instead supply the low bits of a register.

A register request completes one cycle after it is accepted. The caller then writes the returned byte back to the register when the write-enable is high. A memory request runs a read-modify-write over a valid/grant handshake. The block reads the whole byte and modifies one bit. For set, clear, invert and store, it then writes the whole byte back. Test and the carry-logic operations only read. The flag byte passes through the block: only carry and zero can change.

Top module: `bit_manip_unit`

## Requirements
- R1: The bit number is `bit_imm`, except that for set, clear, invert and test (op codes 0 to 3) with `bit_src_reg` high it is `bit_reg`.
- R2: Test (op 3) sets Z (flags bit 2) to the complement of the selected bit, leaves C unchanged, returns the operand unchanged and drives `result_we` low.
- R3: Load (op 4) copies the selected bit into C (flags bit 0). Inverted load (op 5) copies its complement. The operand is returned unchanged with `result_we` low.
- R4: Store (op 6) writes C into the selected bit. Inverted store (op 7) writes the complement of C. `result_we` is high and the flags are unchanged.
- R5: Ops 8/9 (AND / AND-inverted), 10/11 (OR / OR-inverted) and 12/13 (XOR / XOR-inverted) replace C with C combined with the selected bit, or with its complement for the odd codes. Z is unchanged, the operand is returned unchanged and `result_we` is low.
- R6: Set (op 0), clear (op 1) and invert (op 2) force the selected bit to 1, force it to 0 or flip it. All other bits keep their value, `result_we` is high and no flag changes.
- R7: Every flag bit other than C (bit 0) and Z (bit 2) leaves the block equal to the value taken in with the request.
- R8: A register request accepted at a clock edge raises `done` in the following cycle, with no memory access.
- R9: A memory request issues exactly one read. Ops 0, 1, 2, 6 and 7 then issue exactly one write of the whole modified byte; other ops issue no write. With zero grant delay, `done` rises 4 cycles after acceptance for writing ops and 3 for the others.
- R10: While `mem_req` is high without `mem_gnt`, `mem_req`, `mem_we` and `mem_wdata` hold their values into the next cycle.
- R11: Op codes 14 and 15 change nothing: the flags are unchanged, `result_we` is low and no memory write is issued.
- R12: `done` is a single-cycle pulse. `req_ready` is high only while the block is idle, and is high again in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; accepted when `req_ready` is high |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_op | input | 4 | Operation code (0..13, 14/15 no-op) |
| req_mem | input | 1 | 1: operand in memory, 0: operand in `reg_operand` |
| bit_src_reg | input | 1 | Take the bit number from `bit_reg` (ops 0..3 only) |
| bit_imm | input | 3 | Immediate bit number |
| bit_reg | input | 3 | Low bits of the bit-number register |
| reg_operand | input | 8 | Register operand byte |
| flags_in | input | 8 | Current flag byte (C bit 0, Z bit 2) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write access, 0: read access |
| mem_wdata | output | 8 | Byte to write |
| mem_gnt | input | 1 | Memory accepts the access (read data valid) |
| mem_rdata | input | 8 | Read data, valid with `mem_gnt` on a read |
| done | output | 1 | Result valid pulse |
| result_byte | output | 8 | Resulting byte |
| result_we | output | 1 | Byte was modified and is to be written back |
| flags_out | output | 8 | Updated flag byte |

## Verification
A wrong sequencer state shows at the memory port within a cycle. It appears as a write for a read-only op, a second read, a lost request during a stall, or a missing or doubled `done` pulse. The elapsed cycle count from acceptance to `done` exposes a skipped or extra state. A wrong bit number or a faulty combining function shows only in the returned byte or in carry and zero at `done`. Each operation is therefore checked against a model at every bit position, with both carry values and both register and memory operands.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [3:0] {
    OP_BSET    = 4'd0,
    OP_BCLR    = 4'd1,
    OP_BFLIP   = 4'd2,
    OP_BTEST   = 4'd3,
    OP_CLOAD   = 4'd4,
    OP_CLOADN  = 4'd5,
    OP_CSTORE  = 4'd6,
    OP_CSTOREN = 4'd7,
    OP_CAND    = 4'd8,
    OP_CANDN   = 4'd9,
    OP_COR     = 4'd10,
    OP_CORN    = 4'd11,
    OP_CXOR    = 4'd12,
    OP_CXORN   = 4'd13
  } bop_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_READ   = 3'd1,
    S_MODIFY = 3'd2,
    S_WRITE  = 3'd3,
    S_DONE   = 3'd4
  } seq_e;

  // ops whose bit number may come from a register
  function automatic logic op_allows_reg_bitno(input logic [3:0] op);
    return op <= 4'd3;
  endfunction

  // ops that rewrite the operand byte
  function automatic logic op_writes(input logic [3:0] op);
    return (op <= 4'd2) || (op == 4'd6) || (op == 4'd7);
  endfunction

  // combine carry with a (possibly inverted) bit; kind: 0 and, 1 or, 2 xor
  function automatic logic carry_combine(input logic [1:0] kind, input logic c,
                                         input logic b, input logic inv);
    logic v;
    v = b ^ inv;
    case (kind)
      2'd0:    return c & v;
      2'd1:    return c | v;
      default: return c ^ v;
    endcase
  endfunction

endpackage

// File: rtl/bmu_bitsel.sv
module bmu_bitsel #(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic [3:0]       op,
  input  logic             src_reg,
  input  logic [BIT_W-1:0] imm,
  input  logic [BIT_W-1:0] reg_low,
  output logic [DATA_W-1:0] mask
);
  import bmu_pkg::*;

  logic [BIT_W-1:0] bitno;

  assign bitno = (src_reg && op_allows_reg_bitno(op)) ? reg_low : imm;

  for (genvar i = 0; i < DATA_W; i++) begin : g_dec
    assign mask[i] = (bitno == BIT_W'(i));
  end

endmodule

// File: rtl/bmu_alu.sv
module bmu_alu #(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 8,
  parameter int C_POS  = 0,
  parameter int Z_POS  = 2
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] operand,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] result,
  output logic              we,
  output logic [FLAG_W-1:0] flags_out
);
  import bmu_pkg::*;

  logic sel_bit;
  logic c_in;

  assign sel_bit = |(operand & mask);
  assign c_in    = flags_in[C_POS];

  always_comb begin
    result    = operand;
    we        = 1'b0;
    flags_out = flags_in;
    case (op)
      OP_BSET:    begin result = operand | mask;  we = 1'b1; end
      OP_BCLR:    begin result = operand & ~mask; we = 1'b1; end
      OP_BFLIP:   begin result = operand ^ mask;  we = 1'b1; end
      OP_BTEST:   flags_out[Z_POS] = ~sel_bit;
      OP_CLOAD:   flags_out[C_POS] = sel_bit;
      OP_CLOADN:  flags_out[C_POS] = ~sel_bit;
      OP_CSTORE:  begin result = c_in ? (operand | mask) : (operand & ~mask); we = 1'b1; end
      OP_CSTOREN: begin result = c_in ? (operand & ~mask) : (operand | mask); we = 1'b1; end
      OP_CAND, OP_CANDN, OP_COR, OP_CORN, OP_CXOR, OP_CXORN:
        flags_out[C_POS] = carry_combine(2'(({28'd0, op} - 32'd8) >> 1), c_in, sel_bit, op[0]);
      default: ;
    endcase
  end

endmodule

// File: rtl/bmu_seq.sv
module bmu_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_mem,
  input  logic mem_gnt,
  input  logic needs_write,
  output logic req_ready,
  output logic accept,
  output logic cap_read,
  output logic write_fire,
  output logic mem_req,
  output logic mem_we,
  output logic done
);
  import bmu_pkg::*;

  seq_e state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:   if (req_valid) state_nx = req_mem ? S_READ : S_DONE;
      S_READ:   if (mem_gnt) state_nx = S_MODIFY;
      S_MODIFY: state_nx = needs_write ? S_WRITE : S_DONE;
      S_WRITE:  if (mem_gnt) state_nx = S_DONE;
      S_DONE:   state_nx = S_IDLE;
      default:  state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

  assign req_ready  = (state == S_IDLE);
  assign accept     = req_ready && req_valid;
  assign mem_req    = (state == S_READ) || (state == S_WRITE);
  assign mem_we     = (state == S_WRITE);
  assign cap_read   = (state == S_READ) && mem_gnt;
  assign write_fire = (state == S_WRITE) && mem_gnt;
  assign done       = (state == S_DONE);

endmodule

// File: rtl/bit_manip_unit.sv
module bit_manip_unit #(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 8,
  parameter int C_POS  = 0,
  parameter int Z_POS  = 2,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic              req_mem,
  input  logic              bit_src_reg,
  input  logic [BIT_W-1:0]  bit_imm,
  input  logic [BIT_W-1:0]  bit_reg,
  input  logic [DATA_W-1:0] reg_operand,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [DATA_W-1:0] result_byte,
  output logic              result_we,
  output logic [FLAG_W-1:0] flags_out
);

  logic [DATA_W-1:0] mask_in, mask_q, operand_q, alu_result;
  logic [FLAG_W-1:0] flags_q, alu_flags;
  logic [3:0]        op_q;
  logic              alu_we;
  // named events for the checker
  logic ev_accept, ev_read, ev_write;

  bmu_bitsel #(.DATA_W(DATA_W)) u_sel (
    .op(req_op), .src_reg(bit_src_reg), .imm(bit_imm), .reg_low(bit_reg),
    .mask(mask_in)
  );

  bmu_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mem(req_mem),
    .mem_gnt(mem_gnt), .needs_write(alu_we), .req_ready(req_ready),
    .accept(ev_accept), .cap_read(ev_read), .write_fire(ev_write),
    .mem_req(mem_req), .mem_we(mem_we), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= '0;
      mask_q    <= '0;
      operand_q <= '0;
      flags_q   <= '0;
    end else if (ev_accept) begin
      op_q      <= req_op;
      mask_q    <= mask_in;
      operand_q <= reg_operand;
      flags_q   <= flags_in;
    end else if (ev_read) begin
      operand_q <= mem_rdata;
    end
  end

  bmu_alu #(.DATA_W(DATA_W), .FLAG_W(FLAG_W), .C_POS(C_POS), .Z_POS(Z_POS)) u_alu (
    .op(op_q), .mask(mask_q), .operand(operand_q), .flags_in(flags_q),
    .result(alu_result), .we(alu_we), .flags_out(alu_flags)
  );

  assign mem_wdata   = alu_result;
  assign result_byte = alu_result;
  assign result_we   = alu_we;
  assign flags_out   = alu_flags;

endmodule

// File: rtl/bmu_chk.sv
module bmu_chk #(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 8,
  parameter int C_POS  = 0,
  parameter int Z_POS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] result_byte,
  input logic              result_we,
  input logic [FLAG_W-1:0] flags_out,
  input logic [FLAG_W-1:0] flags_q,
  input logic [DATA_W-1:0] operand_q,
  input logic [DATA_W-1:0] mask_q,
  input logic [3:0]        op_q,
  input logic              ev_read,
  input logic              ev_accept
);
  localparam logic [FLAG_W-1:0] CZ = FLAG_W'((1 << C_POS) | (1 << Z_POS));

  logic read_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         read_seen <= 1'b0;
    else if (ev_accept) read_seen <= 1'b0;
    else if (ev_read)   read_seen <= 1'b1;
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_wdata)));

  // R7
  flag_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (((flags_out ^ flags_q) & ~CZ) == '0));

  // R6
  single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result_we) |-> (((result_byte ^ operand_q) & ~mask_q) == '0));

  // R2
  test_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == 4'd3) |-> (!result_we && flags_out[C_POS] == flags_q[C_POS]
                                && flags_out[Z_POS] == ~|(operand_q & mask_q)));

  // R9
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> read_seen);

  // R11
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q >= 4'd14 && (done || mem_req)) |-> (!mem_we && !result_we && flags_out == flags_q));

endmodule

bind bit_manip_unit bmu_chk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W), .C_POS(C_POS), .Z_POS(Z_POS)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .req_ready(req_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_wdata(mem_wdata), .result_byte(result_byte),
  .result_we(result_we), .flags_out(flags_out), .flags_q(flags_q), .operand_q(operand_q),
  .mask_q(mask_q), .op_q(op_q), .ev_read(ev_read), .ev_accept(ev_accept)
);

// File: tb/sim_bit_manip_unit.sv
module sim_bit_manip_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_ready;
  logic [3:0] req_op = '0;
  logic       req_mem = 1'b0, bit_src_reg = 1'b0;
  logic [2:0] bit_imm = '0, bit_reg = '0;
  logic [7:0] reg_operand = '0, flags_in = '0;
  logic       mem_req, mem_we;
  logic [7:0] mem_wdata;
  logic       mem_gnt = 1'b0;
  logic [7:0] mem_rdata = '0;
  logic       done, result_we;
  logic [7:0] result_byte, flags_out;

  int checks = 0;
  int errors = 0;
  int cyc_total = 0;

  always #10 clk = ~clk;

  bit_manip_unit u0 (.*);

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc_total);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench model: returns {we, byte, flags}
  function automatic logic [16:0] model(input logic [3:0] op, input logic [2:0] n,
                                        input logic [7:0] v, input logic [7:0] f);
    logic b, c, w;
    logic [7:0] nv, nf;
    b = v[n]; c = f[0]; nv = v; nf = f; w = 1'b0;
    case (op)
      0: begin nv[n] = 1'b1; w = 1; end
      1: begin nv[n] = 1'b0; w = 1; end
      2: begin nv[n] = !b;   w = 1; end
      3: nf[2] = !b;
      4: nf[0] = b;
      5: nf[0] = !b;
      6: begin nv[n] = c;  w = 1; end
      7: begin nv[n] = !c; w = 1; end
      8: nf[0] = c && b;
      9: nf[0] = c && !b;
      10: nf[0] = c || b;
      11: nf[0] = c || !b;
      12: nf[0] = c != b;
      13: nf[0] = c == b;
      default: ;
    endcase
    return {w, nv, nf};
  endfunction

  task automatic run(input logic [3:0] op, input logic mem, input logic src,
                     input logic [2:0] imm, input logic [2:0] rg, input logic [7:0] val,
                     input logic [7:0] f, input int dly, input logic check_lat);
    logic [16:0] e;
    logic [2:0] n;
    int cyc, reads, writes, waitc;
    logic [7:0] wval;
    string tg;
    n = (src && op <= 3) ? rg : imm;
    e = model(op, n, val, f);
    cyc = 0; reads = 0; writes = 0; waitc = 0; wval = '0;
    @(negedge clk);
    chk("R12 ready when idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1; req_op = op; req_mem = mem; bit_src_reg = src; bit_imm = imm;
    bit_reg = rg; reg_operand = mem ? ~val : val; flags_in = f;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) req_valid = 0;
      mem_gnt = 0;
      if (done) break;
      if (mem_req) begin
        if (waitc < dly) waitc++;
        else begin
          waitc = 0;
          mem_gnt = 1;
          if (!mem_we) begin reads++; mem_rdata = val; end
          else begin writes++; wval = mem_wdata; end
        end
      end
    end
    tg = (op <= 2) ? "R6" : (op == 3) ? "R2" : (op <= 5) ? "R3" : (op <= 7) ? "R4" :
         (op <= 13) ? "R5" : "R11";
    chk({tg, " done seen"}, {31'd0, done}, 32'd1);
    chk({tg, " result byte"}, {24'd0, result_byte}, {24'd0, e[15:8]});
    chk({tg, " write enable"}, {31'd0, result_we}, {31'd0, e[16]});
    chk({tg, " carry/zero"}, {30'd0, flags_out[2], flags_out[0]}, {30'd0, e[2], e[0]});
    chk("R7 other flags", {24'd0, flags_out & 8'hFA}, {24'd0, f & 8'hFA});
    if (src && op <= 3) chk("R1 register bit number", {24'd0, result_byte ^ val}, {24'd0, e[15:8] ^ val});
    if (!mem) chk("R8 register latency", cyc, 1);
    else begin
      chk("R9 one read", reads, 1);
      chk("R9 write count", writes, {31'd0, e[16]});
      if (e[16]) chk("R9 written byte", {24'd0, wval}, {24'd0, e[15:8]});
      if (check_lat) chk("R9 memory latency", cyc, e[16] ? 4 : 3);
    end
    @(negedge clk);
    chk("R12 single done pulse", {30'd0, done, req_ready}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R12 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R12 reset done low", {31'd0, done}, 32'd0);
    chk("R10 reset no request", {31'd0, mem_req}, 32'd0);
    rst_n = 1;
    // directed: every op, every bit, register form
    for (int op = 0; op < 16; op++)
      for (int b = 0; b < 8; b++)
        run(4'(op), 1'b0, 1'b0, 3'(b), 3'(7 - b), 8'hA5 ^ 8'(b * 17), 8'(op * 37 + b), 0, 1'b0);
    // R1: register bit source for ops 0..3 and ignored for the rest
    for (int op = 0; op < 8; op++)
      run(4'(op), 1'b0, 1'b1, 3'd1, 3'd6, 8'h3C, 8'h01, 0, 1'b0);
    // memory form, zero delay, latency checked
    for (int op = 0; op < 16; op++)
      run(4'(op), 1'b1, 1'b0, 3'(op), 3'd0, 8'h96, 8'h05, 0, 1'b1);
    // corners: all-ones and all-zero operands, both carry values
    run(4'd1, 1'b1, 1'b0, 3'd7, 3'd0, 8'hFF, 8'h00, 2, 1'b0);
    run(4'd0, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 8'hFF, 1, 1'b0);
    run(4'd3, 1'b1, 1'b1, 3'd0, 3'd5, 8'h20, 8'h04, 2, 1'b0);
    run(4'd7, 1'b0, 1'b0, 3'd4, 3'd0, 8'h10, 8'h01, 0, 1'b0);
    run(4'd15, 1'b1, 1'b0, 3'd2, 3'd0, 8'h5A, 8'hDB, 1, 1'b0);
    // random mix
    for (int i = 0; i < 400; i++)
      run(4'($urandom_range(15)), 1'($urandom_range(1)), 1'($urandom_range(1)),
          3'($urandom_range(7)), 3'($urandom_range(7)), 8'($urandom_range(255)),
          8'($urandom_range(255)), $urandom_range(2), 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule